// File: doc/BRIEF.md
# Quadrature Modulator with Per-Term Sign Control

This block turns a pair of baseband samples into one real carrier-modulated sample. On every accepted cycle the in-phase sample is multiplied by the cosine carrier sample and the quadrature sample by the sine carrier sample. Both carrier samples come from an oscillator outside the block. Each of the two products can be inverted independently before a single adder combines them. This gives four sign combinations of the I and Q terms, so the spectrum can be mirrored or the carrier phase flipped without touching the oscillator.

The block is a fixed two-stage pipeline. The first stage registers the two signed-adjusted products. The second stage registers their sum and widens it by one guard bit, so no combination of full-scale inputs can wrap. A valid strobe travels alongside the data. Cycles without the strobe leave the pipeline registers untouched, and the output holds its last result.

Top module: `quad_mod`

## Requirements
- R1: With `neg_sel` = 2'b00, an accepted sample produces `out_smp` = i·cos + q·sin.
- R2: With `neg_sel` = 2'b01 (bit 0 set), the I term is inverted: `out_smp` = −i·cos + q·sin.
- R3: With `neg_sel` = 2'b10 (bit 1 set), the Q term is inverted: `out_smp` = i·cos − q·sin.
- R4: With `neg_sel` = 2'b11, both terms are inverted: `out_smp` = −i·cos − q·sin.
- R5: `out_valid` is high exactly two clock edges after each edge at which `in_valid` is high, once per accepted sample, including back-to-back samples.
- R6: Inputs presented while `in_valid` is low have no effect, and `out_smp` holds its last value while `out_valid` is low.
- R7: `out_smp` is DW+CW+1 bits wide and represents the exact sum for all full-scale inputs, for example +2^(DW+CW−1) when all four inputs are at their most negative value and `neg_sel` = 2'b00.
- R8: While `rst_n` is low, `out_valid` and `out_smp` are zero.
- R9: `neg_sel` is taken in the same cycle as its sample, so a different setting on each consecutive sample applies to that sample only.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input sample strobe |
| i_smp | input | DW | Signed in-phase sample |
| q_smp | input | DW | Signed quadrature sample |
| cos_smp | input | CW | Signed cosine carrier sample |
| sin_smp | input | CW | Signed sine carrier sample |
| neg_sel | input | 2 | Bit 0 inverts the I term, bit 1 inverts the Q term |
| out_valid | output | 1 | Output sample strobe |
| out_smp | output | DW+CW+1 | Signed modulated output |

## Verification
Two events can fall in the same cycle. A new sample, possibly with a different sign selection, can enter the product stage while the previous sample's products move into the sum stage. The bench provokes this with directed runs of back-to-back samples that cycle `neg_sel` through all four codes, and with random strobes that leave gaps of varying length. Each output is compared against a bench model that advances two cycles behind the stimulus and keeps the last sum, so any mix of one sample's sign selection or data into another's result shows up as a miscompare.

// File: rtl/quad_mod.sv
module quad_mod #(
  parameter int DW = 12,
  parameter int CW = 12,
  localparam int PW = DW + CW,
  localparam int OW = PW + 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 in_valid,
  input  logic signed [DW-1:0] i_smp,
  input  logic signed [DW-1:0] q_smp,
  input  logic signed [CW-1:0] cos_smp,
  input  logic signed [CW-1:0] sin_smp,
  input  logic [1:0]           neg_sel,
  output logic                 out_valid,
  output logic signed [OW-1:0] out_smp
);

  logic signed [PW-1:0] prod_i, prod_q;
  logic signed [PW-1:0] term_i, term_q;
  logic                 stg_v;

  assign prod_i = i_smp * cos_smp;
  assign prod_q = q_smp * sin_smp;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stg_v     <= 1'b0;
      term_i    <= '0;
      term_q    <= '0;
      out_valid <= 1'b0;
      out_smp   <= '0;
    end else begin
      stg_v     <= in_valid;
      out_valid <= stg_v;
      if (in_valid) begin
        term_i <= neg_sel[0] ? -prod_i : prod_i;
        term_q <= neg_sel[1] ? -prod_q : prod_q;
      end
      if (stg_v)
        out_smp <= {term_i[PW-1], term_i} + {term_q[PW-1], term_q};
    end
  end

endmodule

// File: rtl/quad_mod_chk.sv
module quad_mod_chk #(
  parameter int DW = 12,
  parameter int CW = 12,
  localparam int PW = DW + CW,
  localparam int OW = PW + 1
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 in_valid,
  input logic signed [DW-1:0] i_smp,
  input logic signed [DW-1:0] q_smp,
  input logic signed [CW-1:0] cos_smp,
  input logic signed [CW-1:0] sin_smp,
  input logic [1:0]           neg_sel,
  input logic                 out_valid,
  input logic signed [OW-1:0] out_smp
);

  function automatic logic signed [OW-1:0] mod_ref(
    logic signed [DW-1:0] a, logic signed [DW-1:0] b,
    logic signed [CW-1:0] c, logic signed [CW-1:0] s, logic [1:0] ns);
    logic signed [OW-1:0] ti, tq;
    ti = OW'(a) * OW'(c);
    tq = OW'(b) * OW'(s);
    if (ns[0]) ti = -ti;
    if (ns[1]) tq = -tq;
    return ti + tq;
  endfunction

  localparam logic signed [OW-1:0] LIM = OW'(1) <<< (PW - 1);

  AST_VALID_FWD: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> ##1 out_valid); // R5
  AST_VALID_BACK: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> $past(in_valid, 2)); // R5
  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> $stable(out_smp)); // R6
  AST_SUM_VALUE: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> out_smp == mod_ref($past(i_smp, 2), $past(q_smp, 2),
                                     $past(cos_smp, 2), $past(sin_smp, 2),
                                     $past(neg_sel, 2))); // R1
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    (out_smp <= LIM) && (out_smp >= -LIM)); // R7

endmodule

bind quad_mod quad_mod_chk #(.DW(DW), .CW(CW)) u_chk (.*);

// File: tb/quad_mod_test.sv
module quad_mod_test;
  localparam int CLK_PERIOD = 10;
  localparam int DW = 12;
  localparam int CW = 12;
  localparam int OW = DW + CW + 1;

  logic                 clk = 1'b0;
  logic                 rst_n = 1'b0;
  logic                 in_valid = 1'b0;
  logic signed [DW-1:0] i_smp = '0;
  logic signed [DW-1:0] q_smp = '0;
  logic signed [CW-1:0] cos_smp = '0;
  logic signed [CW-1:0] sin_smp = '0;
  logic [1:0]           neg_sel = '0;
  logic                 out_valid;
  logic signed [OW-1:0] out_smp;

  quad_mod #(.DW(DW), .CW(CW)) uut (.*);

  always #(CLK_PERIOD / 2) clk = ~clk;

  int n_chk = 0;
  int n_bad = 0;

  typedef struct { bit v; longint y; string tag; } exp_t;
  exp_t   e1, e2;
  longint model_y = 0;
  string  tags [4] = '{"R1", "R2", "R3", "R4"};

  function automatic longint ref_y(int a, int b, int c, int s, bit [1:0] ns);
    longint ti, tq;
    ti = longint'(a) * c;
    tq = longint'(b) * s;
    if (ns[0]) ti = -ti;
    if (ns[1]) tq = -tq;
    return ti + tq;
  endfunction

  task automatic check(string tag, longint act, longint exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic step(bit v, int a, int b, int c, int s, bit [1:0] ns, string tag);
    @(negedge clk);
    check("R5", longint'(out_valid), longint'(e2.v));
    if (e2.v) model_y = e2.y;
    check(e2.v ? e2.tag : "R6", longint'(out_smp), model_y);
    e2 = e1;
    e1.v = v;
    e1.y = ref_y(a, b, c, s, ns);
    e1.tag = tag;
    in_valid = v;
    i_smp = DW'(a); q_smp = DW'(b);
    cos_smp = CW'(c); sin_smp = CW'(s);
    neg_sel = ns;
  endtask

  function automatic int rnd(int w);
    return int'($urandom % (32'd1 << w)) - (1 << (w - 1));
  endfunction

  initial begin
    void'($urandom(32'h5eed));
    e1 = '{0, 0, "R6"};
    e2 = '{0, 0, "R6"};
    i_smp = 12'sd700; cos_smp = 12'sd900; in_valid = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R8", longint'(out_valid), 0);
    check("R8", longint'(out_smp), 0);
    in_valid = 1'b0;
    rst_n = 1'b1;
    step(0, 0, 0, 0, 0, 2'b00, "R6");
    step(1, 100, 200, 300, -400, 2'b00, "R1");
    step(1, 100, 200, 300, -400, 2'b01, "R2");
    step(1, 100, 200, 300, -400, 2'b10, "R3");
    step(1, 100, 200, 300, -400, 2'b11, "R4");
    step(0, 2047, 2047, 2047, 2047, 2'b11, "R6");
    step(0, -5, 9, 33, 1, 2'b01, "R6");
    step(0, 0, 0, 0, 0, 2'b00, "R6");
    step(1, -2048, -2048, -2048, -2048, 2'b00, "R7");
    step(1, -2048, -2048, -2048, -2048, 2'b11, "R7");
    step(1, -2048, 2047, 2047, -2048, 2'b00, "R7");
    step(1, -2048, -2048, 2047, 2047, 2'b11, "R7");
    for (int k = 0; k < 16; k++)
      step(1, 1000 - 37 * k, -500 + 61 * k, 1500, -1200, 2'(k), "R9");
    for (int k = 0; k < 500; k++) begin
      bit [1:0] ns = 2'($urandom);
      bit v = ($urandom % 4) != 0;
      step(v, rnd(DW), rnd(DW), rnd(CW), rnd(CW), ns, v ? tags[ns] : "R6");
    end
    for (int k = 0; k < 3; k++) step(0, 0, 0, 0, 0, 2'b00, "R6");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 200000);
    n_bad++;
    $display("FAIL watchdog actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule